// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is a test access port clocked by `tck`. It holds the sixteen-state port controller, a 4-bit instruction register, a 32-bit identification register, a 1-bit bypass register and a boundary-scan chain. The chain is built from a parameterised row of IO cells. Each cell sits between a core side (`core_i` toward the core, `core_o`/`core_oe` from the core) and a pad side (`pad_i` from the pad, `pad_o`/`pad_oe` toward the pad). A 2-bit kind code per cell sets how many scan bits that cell owns and which of its outputs the scan latches take over during the external-test instruction.

An external tester walks the controller with `tms` and shifts `tdi`/`tdo` least significant bit first. Under the sample/preload instruction it takes snapshots of live pin values and preloads update latches. Under the external-test instruction it drives the pads from those latches. `rst_n` is the chip power-on reset. It is asynchronous and active low, and it places the controller in Test-Logic-Reset.

Controller states and the edge taken for TMS=0 / TMS=1:
- Test-Logic-Reset: Run-Test/Idle / stay.
- Run-Test/Idle: stay / Select-DR.
- Select-DR: Capture-DR / Select-IR.
- Select-IR: Capture-IR / Test-Logic-Reset.

The two scan columns move the same way. In the list below, X stands for DR or IR.
- Capture-X: Shift-X / Exit1-X.
- Shift-X: stay / Exit1-X.
- Exit1-X: Pause-X / Update-X.
- Pause-X: stay / Exit2-X.
- Exit2-X: Shift-X / Update-X.
- Update-X: Run-Test/Idle / Select-DR.

Top module: `jtag_bscan_tap`

## Requirements
- R1: `rst_n` low, or five consecutive rising `tck` edges with `tms` high from any state, puts the controller in Test-Logic-Reset. That state loads instruction 0x1 (identification).
- R2: Instruction 0x1 selects a 32-bit data register. Capture loads it with 0x000018FF, and it shifts out least significant bit first.
- R3: Capture-IR loads the binary pattern 0001 into the instruction shift stage, which shifts toward `tdo`. The instruction in force changes only at the rising edge that leaves Update-IR, or in Test-Logic-Reset.
- R4: Every instruction code other than 0x0, 0x1 and 0x2 selects a 1-bit bypass register. It captures 0, so a DR scan returns the input delayed by one bit.
- R5: Kind codes are 0 input (one bit: i), 1 output (one bit: o), 2 tristate (two bits: o then oe) and 3 bidirectional (three bits: i, o, oe). Cell 0 lies nearest `tdo`. Within a cell the first listed bit is the one nearest `tdo`.
- R6: Capture-DR under instruction 0x0 or 0x2 loads `pad_i` into i bits, `core_o` into o bits and `core_oe` into oe bits.
- R7: The rising edge leaving Update-DR copies the chain's shift stage into its update latches, but only under instruction 0x0 or 0x2. Under any other instruction the latches keep their value.
- R8: Under any instruction other than 0x2, every cell passes `pad_i` to `core_i`, `core_o` to `pad_o` and `core_oe` to `pad_oe`.
- R9: Under instruction 0x2, the cells take their outputs from their update latches:
  - An input cell drives `pad_o`=0, `pad_oe`=0 and `core_i` = latch i.
  - An output cell drives `pad_o` = latch o and `pad_oe`=1.
  - A tristate cell drives latch o and latch oe to the pad.
  - A bidirectional cell drives latch o and latch oe to the pad and latch i to `core_i`.
  - Output and tristate cells keep `core_i` = `pad_i`.
  - Changes on `core_o` and `core_oe` do not reach the pad.
- R10: `tdo` and `tdo_en` change on the falling edge of `tck`. `tdo_en` is high only while the controller is in Shift-IR or Shift-DR. Otherwise `tdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, falling-edge register |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| pad_i | input | N_CELLS | Values arriving from the pads |
| core_o | input | N_CELLS | Output values from the core |
| core_oe | input | N_CELLS | Output enables from the core |
| core_i | output | N_CELLS | Values delivered to the core |
| pad_o | output | N_CELLS | Values driven to the pads |
| pad_oe | output | N_CELLS | Output enables driven to the pads |

## Verification
The cell paths are combinational from the instruction and latch registers, so a pin result is due in the same cycle once those registers settle. The bench checks pins 1 ns after it changes a pin, or 1 ns after the rising edge that leaves Update-IR or Update-DR.

A scanned bit is due on `tdo` at the falling edge after the rising edge that entered the shift state. Each later bit follows one falling edge after the previous one. The bench therefore drives `tms`/`tdi` and samples `tdo` 1 ns after each falling edge, so every sample pairs with the bit shifted on the next rising edge. One directed case samples `tdo` on both sides of the first falling edge, to show that it does not move at the rising edge.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET,
        TS_IDLE,
        TS_SEL_DR,
        TS_CAP_DR,
        TS_SHIFT_DR,
        TS_EXIT1_DR,
        TS_PAUSE_DR,
        TS_EXIT2_DR,
        TS_UPD_DR,
        TS_SEL_IR,
        TS_CAP_IR,
        TS_SHIFT_IR,
        TS_EXIT1_IR,
        TS_PAUSE_IR,
        TS_EXIT2_IR,
        TS_UPD_IR
    } tap_state_t;

    localparam int IR_W = 4;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'h0;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'h1;
    localparam logic [IR_W-1:0] OP_EXTEST = 4'h2;
    localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

    localparam logic [1:0] KIND_IN    = 2'd0;
    localparam logic [1:0] KIND_OUT   = 2'd1;
    localparam logic [1:0] KIND_TRI   = 2'd2;
    localparam logic [1:0] KIND_BIDIR = 2'd3;

    function automatic int kind_width(logic [1:0] kind);
        case (kind)
            KIND_TRI:   return 2;
            KIND_BIDIR: return 3;
            default:    return 1;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state,
    output logic       in_reset,
    output logic       cap_dr,
    output logic       sh_dr,
    output logic       upd_dr,
    output logic       cap_ir,
    output logic       sh_ir,
    output logic       upd_ir
);

    tap_state_t state_q, state_d;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= TS_RESET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TS_RESET:    state_d = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_DR:   state_d = tms ? TS_SEL_IR   : TS_CAP_DR;
            TS_CAP_DR:   state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_SHIFT_DR: state_d = tms ? TS_EXIT1_DR : TS_SHIFT_DR;
            TS_EXIT1_DR: state_d = tms ? TS_UPD_DR   : TS_PAUSE_DR;
            TS_PAUSE_DR: state_d = tms ? TS_EXIT2_DR : TS_PAUSE_DR;
            TS_EXIT2_DR: state_d = tms ? TS_UPD_DR   : TS_SHIFT_DR;
            TS_UPD_DR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
            TS_SEL_IR:   state_d = tms ? TS_RESET    : TS_CAP_IR;
            TS_CAP_IR:   state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_SHIFT_IR: state_d = tms ? TS_EXIT1_IR : TS_SHIFT_IR;
            TS_EXIT1_IR: state_d = tms ? TS_UPD_IR   : TS_PAUSE_IR;
            TS_PAUSE_IR: state_d = tms ? TS_EXIT2_IR : TS_PAUSE_IR;
            TS_EXIT2_IR: state_d = tms ? TS_UPD_IR   : TS_SHIFT_IR;
            TS_UPD_IR:   state_d = tms ? TS_SEL_DR   : TS_IDLE;
        endcase
    end

    always_comb begin
        in_reset = (state_q == TS_RESET);
        cap_dr   = (state_q == TS_CAP_DR);
        sh_dr    = (state_q == TS_SHIFT_DR);
        upd_dr   = (state_q == TS_UPD_DR);
        cap_ir   = (state_q == TS_CAP_IR);
        sh_ir    = (state_q == TS_SHIFT_IR);
        upd_ir   = (state_q == TS_UPD_IR);
    end

    assign state = state_q;

endmodule

// File: rtl/tap_instr.sv
module tap_instr
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            rst_n,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            cap_ir,
    input  logic            sh_ir,
    input  logic            upd_ir,
    output logic [IR_W-1:0] ir,
    output logic            sr_out
);

    logic [IR_W-1:0] sr_q, ir_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
            ir_q <= OP_IDCODE;
        end else begin
            if (cap_ir)     sr_q <= IR_CAPTURE;
            else if (sh_ir) sr_q <= {tdi, sr_q[IR_W-1:1]};
            if (in_reset)    ir_q <= OP_IDCODE;
            else if (upd_ir) ir_q <= sr_q;
        end
    end

    assign ir     = ir_q;
    assign sr_out = sr_q[0];

endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
    import tap_pkg::*;
#(
    parameter logic [1:0] KIND = KIND_BIDIR
) (
    input  logic tck,
    input  logic rst_n,
    input  logic cap,
    input  logic shift,
    input  logic upd,
    input  logic extest,
    input  logic si,
    output logic so,
    input  logic pad_i,
    input  logic core_o,
    input  logic core_oe,
    output logic core_i,
    output logic pad_o,
    output logic pad_oe
);

    localparam int W = kind_width(KIND);

    logic [W-1:0] sr_q, lat_q, cap_v;
    logic [W:0]   sr_ext;
    logic         x_core_i, x_pad_o, x_pad_oe;

    assign sr_ext = {si, sr_q};

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            lat_q <= '0;
        end else begin
            if (cap)        sr_q <= cap_v;
            else if (shift) sr_q <= sr_ext[W:1];
            if (upd)        lat_q <= sr_q;
        end
    end

    assign so = sr_q[0];

    generate
        if (KIND == KIND_IN) begin : g_in
            assign cap_v    = pad_i;
            assign x_core_i = lat_q[0];
            assign x_pad_o  = 1'b0;
            assign x_pad_oe = 1'b0;
        end else if (KIND == KIND_OUT) begin : g_out
            assign cap_v    = core_o;
            assign x_core_i = pad_i;
            assign x_pad_o  = lat_q[0];
            assign x_pad_oe = 1'b1;
        end else if (KIND == KIND_TRI) begin : g_tri
            assign cap_v    = {core_oe, core_o};
            assign x_core_i = pad_i;
            assign x_pad_o  = lat_q[0];
            assign x_pad_oe = lat_q[1];
        end else begin : g_bidir
            assign cap_v    = {core_oe, core_o, pad_i};
            assign x_core_i = lat_q[0];
            assign x_pad_o  = lat_q[1];
            assign x_pad_oe = lat_q[2];
        end
    endgenerate

    assign core_i = extest ? x_core_i : pad_i;
    assign pad_o  = extest ? x_pad_o  : core_o;
    assign pad_oe = extest ? x_pad_oe : core_oe;

endmodule

// File: rtl/jtag_bscan_tap.sv
module jtag_bscan_tap
    import tap_pkg::*;
#(
    parameter int                   N_CELLS    = 4,
    parameter logic [2*N_CELLS-1:0] CELL_KINDS = 8'b11_10_01_00,
    parameter int                   ID_W       = 32,
    parameter logic [ID_W-1:0]      ID_VALUE   = 32'h0000_18FF
) (
    input  logic               tck,
    input  logic               rst_n,
    input  logic               tms,
    input  logic               tdi,
    output logic               tdo,
    output logic               tdo_en,
    input  logic [N_CELLS-1:0] pad_i,
    input  logic [N_CELLS-1:0] core_o,
    input  logic [N_CELLS-1:0] core_oe,
    output logic [N_CELLS-1:0] core_i,
    output logic [N_CELLS-1:0] pad_o,
    output logic [N_CELLS-1:0] pad_oe
);

    tap_state_t      state_w;
    logic            in_reset, cap_dr, sh_dr, upd_dr, cap_ir, sh_ir, upd_ir;
    logic [IR_W-1:0] ir_w;
    logic            ir_out;

    tap_fsm u_fsm (
        .tck(tck), .rst_n(rst_n), .tms(tms), .state(state_w),
        .in_reset(in_reset), .cap_dr(cap_dr), .sh_dr(sh_dr), .upd_dr(upd_dr),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir)
    );

    tap_instr u_ir (
        .tck(tck), .rst_n(rst_n), .tdi(tdi), .in_reset(in_reset),
        .cap_ir(cap_ir), .sh_ir(sh_ir), .upd_ir(upd_ir),
        .ir(ir_w), .sr_out(ir_out)
    );

    logic sel_bnd, sel_id, sel_byp, extest;
    assign extest  = (ir_w == OP_EXTEST);
    assign sel_bnd = (ir_w == OP_SAMPLE) || extest;
    assign sel_id  = (ir_w == OP_IDCODE);
    assign sel_byp = !sel_bnd && !sel_id;

    logic [ID_W-1:0] id_q;
    logic            byp_q;

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            id_q  <= '0;
            byp_q <= 1'b0;
        end else begin
            if (sel_id && cap_dr)     id_q <= ID_VALUE;
            else if (sel_id && sh_dr) id_q <= {tdi, id_q[ID_W-1:1]};
            if (sel_byp && cap_dr)     byp_q <= 1'b0;
            else if (sel_byp && sh_dr) byp_q <= tdi;
        end
    end

    logic [N_CELLS:0] link;
    assign link[N_CELLS] = tdi;

    generate
        for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
            bscan_cell #(.KIND(CELL_KINDS[2*g +: 2])) u_cell (
                .tck(tck), .rst_n(rst_n),
                .cap(sel_bnd && cap_dr), .shift(sel_bnd && sh_dr),
                .upd(sel_bnd && upd_dr), .extest(extest),
                .si(link[g+1]), .so(link[g]),
                .pad_i(pad_i[g]), .core_o(core_o[g]), .core_oe(core_oe[g]),
                .core_i(core_i[g]), .pad_o(pad_o[g]), .pad_oe(pad_oe[g])
            );
        end
    endgenerate

    logic dr_out;
    always_comb begin
        if (sel_bnd)     dr_out = link[0];
        else if (sel_id) dr_out = id_q[0];
        else             dr_out = byp_q;
    end

    logic tdo_q, tdo_en_q;
    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) begin
            tdo_q    <= 1'b0;
            tdo_en_q <= 1'b0;
        end else begin
            tdo_en_q <= sh_ir || sh_dr;
            tdo_q    <= sh_ir ? ir_out : (sh_dr ? dr_out : 1'b0);
        end
    end

    assign tdo    = tdo_q;
    assign tdo_en = tdo_en_q;

endmodule

// File: rtl/tap_chk.sv
module tap_chk
    import tap_pkg::*;
#(
    parameter int N = 4
) (
    input logic            tck,
    input logic            rst_n,
    input logic            tms,
    input logic            tdo,
    input logic            tdo_en,
    input logic [N-1:0]    pad_i,
    input logic [N-1:0]    core_o,
    input logic [N-1:0]    core_oe,
    input logic [N-1:0]    core_i,
    input logic [N-1:0]    pad_o,
    input logic [N-1:0]    pad_oe,
    input tap_state_t      state,
    input logic [IR_W-1:0] ir
);

    logic [2:0] ones_q;
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n)      ones_q <= '0;
        else if (!tms)   ones_q <= '0;
        else if (ones_q != 3'd7) ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!rst_n)
        (ones_q >= 3'd5) |-> (state == TS_RESET)); // R1

    AST_RESET_LOADS_ID: assert property (@(posedge tck) disable iff (!rst_n)
        (state == TS_RESET) |=> (ir == OP_IDCODE)); // R1

    AST_IR_HELD: assert property (@(posedge tck) disable iff (!rst_n)
        (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir)); // R3

    AST_TDO_EN_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_en == (state == TS_SHIFT_DR || state == TS_SHIFT_IR)); // R10

    AST_TDO_QUIET: assert property (@(posedge tck) disable iff (!rst_n)
        !tdo_en |-> (tdo == 1'b0)); // R10

    AST_NORMAL_PASS: assert property (@(posedge tck) disable iff (!rst_n)
        (ir != OP_EXTEST) |-> (pad_o == core_o && pad_oe == core_oe && core_i == pad_i)); // R8

    AST_EXTEST_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
        (ir == OP_EXTEST && state != TS_UPD_DR && state != TS_UPD_IR && state != TS_RESET)
        |=> ($stable(pad_o) && $stable(pad_oe))); // R9

endmodule

bind jtag_bscan_tap tap_chk #(.N(N_CELLS)) u_chk (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdo(tdo), .tdo_en(tdo_en),
    .pad_i(pad_i), .core_o(core_o), .core_oe(core_oe),
    .core_i(core_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .state(state_w), .ir(ir_w)
);

// File: tb/sim_jtag_bscan_tap.sv
`timescale 1ns/1ps
module sim_jtag_bscan_tap;

    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       tdo, tdo_en;
    logic [3:0] pad_i = '0, core_o = '0, core_oe = '0;
    logic [3:0] core_i, pad_o, pad_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 tck = ~tck;

    jtag_bscan_tap u0 (
        .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .pad_i(pad_i), .core_o(core_o), .core_oe(core_oe),
        .core_i(core_i), .pad_o(pad_o), .pad_oe(pad_oe)
    );

    // {pad_i, core_o, core_oe}
    localparam logic [11:0] VEC [0:5] = '{12'hF00, 12'h0F0, 12'h00F, 12'hA5C, 12'h369, 12'hC3A};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic so);
        @(negedge tck);
        #1;
        so  = tdo;
        tms = m;
        tdi = d;
    endtask

    task automatic settle();
        @(posedge tck);
        #1;
    endtask

    task automatic tap_reset();
        logic s;
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, s);
        step(1'b0, 1'b0, s);
        settle();
    endtask

    task automatic scan_ir(input logic [3:0] v, output logic [3:0] cap);
        logic s;
        step(1, 0, s); step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int k = 0; k < 4; k++) begin
            step(k == 3, v[k], s);
            cap[k] = s;
        end
        step(1, 0, s); step(0, 0, s);
        settle();
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic s;
        dout = '0;
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        for (int k = 0; k < n; k++) begin
            step(k == n - 1, din[k], s);
            dout[k] = s;
        end
        step(1, 0, s); step(0, 0, s);
        settle();
    endtask

    function automatic logic [6:0] exp_chain(logic [3:0] pi, logic [3:0] co, logic [3:0] coe);
        return {coe[3], co[3], pi[3], coe[2], co[2], co[1], pi[0]};
    endfunction

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0]  irc;
        logic [63:0] d;
        logic        s;

        repeat (3) @(posedge tck);
        #1;
        check("R10 reset tdo_en", tdo_en, 0);
        check("R10 reset tdo", tdo, 0);
        @(negedge tck);
        rst_n = 1'b1;
        step(0, 0, s);
        settle();

        scan_dr(32, 64'h0, d);
        check("R1 R2 id after reset", d, 64'h0000_18FF);

        scan_ir(4'hF, irc);
        check("R3 IR capture pattern", irc, 4'b0001);
        scan_dr(8, 64'hA5, d);
        check("R4 bypass code F", d, 64'h4A);
        scan_ir(4'h7, irc);
        scan_dr(8, 64'h3C, d);
        check("R4 bypass code 7", d, 64'h78);

        // R6 R8 table walk under sample/preload
        scan_ir(4'h0, irc);
        for (int v = 0; v < 6; v++) begin
            {pad_i, core_o, core_oe} = VEC[v];
            #1;
            check("R8 core_i pass", core_i, pad_i);
            check("R8 pad_o pass", pad_o, core_o);
            check("R8 pad_oe pass", pad_oe, core_oe);
            scan_dr(7, 64'h0, d);
            check("R5 R6 sample capture", d, {57'h0, exp_chain(pad_i, core_o, core_oe)});
        end

        // preload, then external test
        scan_dr(7, 64'b1010110, d);
        pad_i = 4'b1001; core_o = 4'h0; core_oe = 4'h0;
        scan_ir(4'h2, irc);
        check("R9 extest pad_o", pad_o, 4'b0110);
        check("R9 extest pad_oe", pad_oe, 4'b1010);
        check("R9 extest core_i", core_i, 4'b1000);
        core_o = 4'hF; core_oe = 4'hF;
        #1;
        check("R9 core_o ignored", pad_o, 4'b0110);
        check("R9 core_oe ignored", pad_oe, 4'b1010);
        scan_dr(7, 64'b0001001, d);
        check("R6 extest capture", d, 64'h7F);
        check("R7 update pad_o", pad_o, 4'b0000);
        check("R7 update pad_oe", pad_oe, 4'b0110);
        check("R7 update core_i", core_i, 4'b0001);

        // R7 latches hold under another instruction
        scan_ir(4'h1, irc);
        check("R8 pass after leaving extest", pad_o, core_o);
        scan_dr(32, 64'hFFFF_FFFF, d);
        scan_ir(4'h2, irc);
        check("R7 latches kept pad_o", pad_o, 4'b0000);
        check("R7 latches kept pad_oe", pad_oe, 4'b0110);

        // R1 five TMS-high edges from mid Shift-DR
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        tap_reset();
        core_o = 4'h5;
        #1;
        check("R1 R8 pass after tms reset", pad_o, 4'h5);
        check("R10 idle tdo_en", tdo_en, 0);
        scan_dr(32, 64'h0, d);
        check("R1 id after tms reset", d, 64'h0000_18FF);

        // R10 tdo moves on the falling edge
        step(1, 0, s); step(0, 0, s); step(0, 0, s);
        @(posedge tck);
        #1;
        check("R10 tdo before falling edge", tdo, 0);
        check("R10 tdo_en before falling edge", tdo_en, 0);
        @(negedge tck);
        #1;
        check("R10 tdo after falling edge", tdo, 1);
        check("R10 tdo_en in shift", tdo_en, 1);
        step(1, 0, s); step(1, 0, s); step(0, 0, s);
        settle();
        check("R10 tdo_en after exit", tdo_en, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule